// File: doc/BRIEF.md
# Load Fill Request Queue

This block holds loads that missed the first-level data cache while their line is being fetched. It is a small pool of slots. Each occupied slot keeps the load's address, its merge data and byte mask, a destination tag and a thread ID. A slot is always in exactly one of three states: free, waiting for its line, or ready to be handed back to the pipeline. The block tracks the states as three per-slot bitmaps. Slots have no FIFO order. A slot moves from one map to another in response to allocation, a wakeup bitmask, a retirement, an annul, a per-thread flush or a global restart.

The load path asks for a slot and gets its index back in the same cycle. Later, the miss-handling logic marks slots ready by bitmask when their line lands. The queue then retires up to two ready slots per cycle, lowest index first. Each retirement puts out the slot's tag, address, merge data and byte mask, and the slot returns to the free pool. The queue also sums the time each request spent in the queue, from allocation to retirement. Any sample of 65536 cycles or more is dropped as counter wraparound.

Top module: `ldfill_queue`

## Requirements
- R1: Each slot is in exactly one of the states free, waiting or ready. After reset every slot is free, `occupancy` is 0, `full` is 0 and nothing retires.
- R2: An allocation request gets the lowest-indexed free slot. `alloc_ok` and `alloc_slot` are valid in the same cycle, and the slot is waiting from the next cycle on. With no free slot, `alloc_ok` is 0 and no state changes.
- R3: Every waiting slot whose bit is set in `wake_mask` is ready from the next cycle. Mask bits for free or ready slots have no effect.
- R4: In each cycle, the ready slots are retired on up to two lanes, lowest index first, with lane 0 carrying the lower index. Each lane shows the slot's tag, address, data and byte mask. The slot is free from the next cycle. `ret_count` gives the number of valid lanes (0, 1 or 2), and the valid lanes are always lane 0 upward.
- R5: An annul of an occupied slot frees it from the next cycle. In the same cycle the annul raises `mb_drop_req`, with `mb_drop_slot` set to the annulled slot. An annul of a free slot changes nothing and raises no drop.
- R6: A flush frees, from the next cycle, every occupied slot whose thread ID equals `flush_tid`. Slots of other threads keep their state.
- R7: A restart frees every slot from the next cycle and refuses any allocation in the same cycle.
- R8: A slot that is annulled, flushed or restarted in a cycle is not retired in that cycle. Its place on the lanes goes to the next ready slot.
- R9: For each retirement, the latency is the retirement cycle minus the allocation cycle. If the latency is below 65536 it is added to `lat_total` at the next edge, and otherwise it is discarded.
- R10: `occupancy` equals the number of non-free slots, and `full` is 1 exactly when it equals the depth.
- R11: Allocation, wakeup and retirement in the same cycle each take effect independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Request a slot |
| alloc_addr | input | ADDR_W | Load address |
| alloc_data | input | DATA_W | Merge data |
| alloc_bmask | input | BMASK_W | Merge byte mask |
| alloc_tag | input | TAG_W | Destination tag |
| alloc_tid | input | TID_W | Thread ID |
| alloc_ok | output | 1 | Slot granted this cycle |
| alloc_slot | output | IDX_W | Granted slot index |
| wake_mask | input | DEPTH | Slots whose line has arrived |
| annul_req | input | 1 | Annul one slot |
| annul_slot | input | IDX_W | Slot to annul |
| mb_drop_req | output | 1 | Tell the miss buffer to drop a slot |
| mb_drop_slot | output | IDX_W | Slot to drop |
| flush_req | input | 1 | Flush one thread |
| flush_tid | input | TID_W | Thread to flush |
| restart_req | input | 1 | Empty the whole queue |
| ret_valid | output | RET_W | Lane valid |
| ret_slot | output | RET_W x IDX_W | Retired slot per lane |
| ret_tag | output | RET_W x TAG_W | Tag per lane |
| ret_addr | output | RET_W x ADDR_W | Address per lane |
| ret_data | output | RET_W x DATA_W | Merge data per lane |
| ret_bmask | output | RET_W x BMASK_W | Byte mask per lane |
| ret_count | output | RC_W | Number of lanes valid |
| occupancy | output | CNT_W | Non-free slot count |
| full | output | 1 | No free slot |
| lat_total | output | SUM_W | Sum of accepted latencies |

## Verification
The bench goes after several corner cases, each with the failure a wrong design would show:
- Allocation into a full queue: a design that grants anyway would overwrite a live slot.
- Wakeup bits aimed at free or already ready slots: a careless design would make phantom ready entries that retire with stale payloads.
- A slot annulled or flushed in the very cycle it would retire: it must not appear on a lane, and a design that lets it through would wake a load that was squashed.
- A restart that coincides with an allocation request: the request must be refused.
- A request held past the 65536-cycle wraparound limit: a design without the limit would add a huge bogus latency to the total.
- Long mixed traffic against the reference model: this shows any drift between the occupancy counter and the maps, which would otherwise surface as a false full or as lost slots.

// File: rtl/lfq_pkg.sv
package lfq_pkg;

    localparam int LFQ_MAX_SLOTS = 64;

    typedef logic [LFQ_MAX_SLOTS-1:0] slot_vec_t;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;

    // Index of the lowest set bit, or -1 when the vector is empty.
    function automatic int lowest_set(input slot_vec_t v);
        int r;
        r = -1;
        for (int i = LFQ_MAX_SLOTS - 1; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

    function automatic int popcnt(input slot_vec_t v);
        int n;
        n = 0;
        for (int i = 0; i < LFQ_MAX_SLOTS; i++) begin
            n = n + int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/lfq_picker.sv
// Picks up to LANES lowest set bits of a candidate vector, lane 0 lowest.
module lfq_picker
    import lfq_pkg::*;
#(
    parameter int N     = 8,
    parameter int LANES = 2,
    parameter int IW    = 3
) (
    input  logic [N-1:0]               cand,
    output logic [LANES-1:0]           hit,
    output logic [LANES-1:0][IW-1:0]   idx,
    output logic [N-1:0]               grant
);

    logic [LANES:0][N-1:0] remain;

    assign remain[0] = cand;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            slot_vec_t ext;
            int        pos;
            logic [N-1:0] onehot;

            always_comb begin
                ext       = '0;
                ext[N-1:0] = remain[l];
                pos       = lowest_set(ext);
                onehot    = '0;
                if (pos >= 0) onehot[pos] = 1'b1;
            end

            assign hit[l]       = (pos >= 0);
            assign idx[l]       = (pos >= 0) ? IW'(pos) : '0;
            assign remain[l+1]  = remain[l] & ~onehot;
        end
    endgenerate

    assign grant = cand & ~remain[LANES];

endmodule

// File: rtl/lfq_payload.sv
// Per-slot request storage with lane read ports and a thread-ID view.
module lfq_payload #(
    parameter int DEPTH   = 8,
    parameter int IDX_W   = 3,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int BMASK_W = 8,
    parameter int TAG_W   = 8,
    parameter int TID_W   = 2,
    parameter int CYC_W   = 32,
    parameter int RET_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [IDX_W-1:0]                  widx,
    input  logic [ADDR_W-1:0]                 w_addr,
    input  logic [DATA_W-1:0]                 w_data,
    input  logic [BMASK_W-1:0]                w_bmask,
    input  logic [TAG_W-1:0]                  w_tag,
    input  logic [TID_W-1:0]                  w_tid,
    input  logic [CYC_W-1:0]                  w_stamp,
    input  logic [RET_W-1:0][IDX_W-1:0]       ridx,
    output logic [RET_W-1:0][ADDR_W-1:0]      r_addr,
    output logic [RET_W-1:0][DATA_W-1:0]      r_data,
    output logic [RET_W-1:0][BMASK_W-1:0]     r_bmask,
    output logic [RET_W-1:0][TAG_W-1:0]       r_tag,
    output logic [RET_W-1:0][CYC_W-1:0]       r_stamp,
    output logic [DEPTH-1:0][TID_W-1:0]       tid_all
);

    logic [DEPTH-1:0][ADDR_W-1:0]  addr_q;
    logic [DEPTH-1:0][DATA_W-1:0]  data_q;
    logic [DEPTH-1:0][BMASK_W-1:0] bmask_q;
    logic [DEPTH-1:0][TAG_W-1:0]   tag_q;
    logic [DEPTH-1:0][TID_W-1:0]   tid_q;
    logic [DEPTH-1:0][CYC_W-1:0]   stamp_q;

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    addr_q[s]  <= '0;
                    data_q[s]  <= '0;
                    bmask_q[s] <= '0;
                    tag_q[s]   <= '0;
                    tid_q[s]   <= '0;
                    stamp_q[s] <= '0;
                end else if (we && (widx == IDX_W'(s))) begin
                    addr_q[s]  <= w_addr;
                    data_q[s]  <= w_data;
                    bmask_q[s] <= w_bmask;
                    tag_q[s]   <= w_tag;
                    tid_q[s]   <= w_tid;
                    stamp_q[s] <= w_stamp;
                end
            end
        end

        for (genvar l = 0; l < RET_W; l++) begin : g_rd
            assign r_addr[l]  = addr_q[ridx[l]];
            assign r_data[l]  = data_q[ridx[l]];
            assign r_bmask[l] = bmask_q[ridx[l]];
            assign r_tag[l]   = tag_q[ridx[l]];
            assign r_stamp[l] = stamp_q[ridx[l]];
        end
    endgenerate

    assign tid_all = tid_q;

endmodule

// File: rtl/lfq_state.sv
// Free / waiting / ready bitmaps and the occupancy counter.
module lfq_state
    import lfq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEPTH-1:0]  alloc_oh,
    input  logic [DEPTH-1:0]  wake_mask,
    input  logic [DEPTH-1:0]  kill,
    input  logic [DEPTH-1:0]  ret_grant,
    output logic [DEPTH-1:0]  free_q,
    output logic [DEPTH-1:0]  wait_q,
    output logic [DEPTH-1:0]  ready_q,
    output logic [CNT_W-1:0]  count_q
);

    logic [DEPTH-1:0] free_n, wait_n, ready_n;
    logic [CNT_W-1:0] count_n;
    slot_vec_t        kill_ext, ret_ext, alloc_ext;

    always_comb begin
        kill_ext  = '0;
        ret_ext   = '0;
        alloc_ext = '0;
        kill_ext[DEPTH-1:0]  = kill;
        ret_ext[DEPTH-1:0]   = ret_grant;
        alloc_ext[DEPTH-1:0] = alloc_oh;

        // R2, R5, R6, R7: freed by kill or retirement, taken by allocation
        free_n  = (free_q & ~alloc_oh) | kill | ret_grant;
        // R3: wakeup only moves slots that are waiting now
        wait_n  = (wait_q & ~wake_mask & ~kill) | alloc_oh;
        ready_n = ((ready_q & ~ret_grant) | (wait_q & wake_mask)) & ~kill;

        count_n = count_q
                + CNT_W'(popcnt(alloc_ext))
                - CNT_W'(popcnt(kill_ext))
                - CNT_W'(popcnt(ret_ext));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q  <= '1;
            wait_q  <= '0;
            ready_q <= '0;
            count_q <= '0;
        end else begin
            free_q  <= free_n;
            wait_q  <= wait_n;
            ready_q <= ready_n;
            count_q <= count_n;
        end
    end

endmodule

// File: rtl/ldfill_queue.sv
module ldfill_queue
    import lfq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int BMASK_W   = 8,
    parameter int TAG_W     = 8,
    parameter int TID_W     = 2,
    parameter int RET_W     = 2,
    parameter int CYC_W     = 32,
    parameter int SUM_W     = 32,
    parameter int LAT_LIMIT = 65536,
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int RC_W     = $clog2(RET_W + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           alloc_req,
    input  logic [ADDR_W-1:0]              alloc_addr,
    input  logic [DATA_W-1:0]              alloc_data,
    input  logic [BMASK_W-1:0]             alloc_bmask,
    input  logic [TAG_W-1:0]               alloc_tag,
    input  logic [TID_W-1:0]               alloc_tid,
    output logic                           alloc_ok,
    output logic [IDX_W-1:0]               alloc_slot,
    input  logic [DEPTH-1:0]               wake_mask,
    input  logic                           annul_req,
    input  logic [IDX_W-1:0]               annul_slot,
    output logic                           mb_drop_req,
    output logic [IDX_W-1:0]               mb_drop_slot,
    input  logic                           flush_req,
    input  logic [TID_W-1:0]               flush_tid,
    input  logic                           restart_req,
    output logic [RET_W-1:0]               ret_valid,
    output logic [RET_W-1:0][IDX_W-1:0]    ret_slot,
    output logic [RET_W-1:0][TAG_W-1:0]    ret_tag,
    output logic [RET_W-1:0][ADDR_W-1:0]   ret_addr,
    output logic [RET_W-1:0][DATA_W-1:0]   ret_data,
    output logic [RET_W-1:0][BMASK_W-1:0]  ret_bmask,
    output logic [RC_W-1:0]                ret_count,
    output logic [CNT_W-1:0]               occupancy,
    output logic                           full,
    output logic [SUM_W-1:0]               lat_total
);

    logic [DEPTH-1:0]              free_map, wait_map, ready_map;
    logic [DEPTH-1:0]              kill, ret_cand, ret_grant, alloc_grant, alloc_oh;
    logic [DEPTH-1:0][TID_W-1:0]   tid_all;
    logic [0:0]                    alloc_hit;
    logic [0:0][IDX_W-1:0]         alloc_idx;
    logic                          alloc_fire;
    logic [RET_W-1:0][CYC_W-1:0]   ret_stamp;
    logic [CYC_W-1:0]              cyc_q;
    logic [SUM_W-1:0]              lat_add;

    // R5, R6, R7: slots removed this cycle; only occupied slots count
    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            kill[s] = !free_map[s] &&
                      (restart_req ||
                       (annul_req && (annul_slot == IDX_W'(s))) ||
                       (flush_req && (tid_all[s] == flush_tid)));
        end
    end

    // R8: a slot being removed is not offered for retirement
    assign ret_cand = ready_map & ~kill;

    lfq_picker #(.N(DEPTH), .LANES(RET_W), .IW(IDX_W)) u_ret_pick (
        .cand  (ret_cand),
        .hit   (ret_valid),
        .idx   (ret_slot),
        .grant (ret_grant)
    );

    lfq_picker #(.N(DEPTH), .LANES(1), .IW(IDX_W)) u_alloc_pick (
        .cand  (free_map),
        .hit   (alloc_hit),
        .idx   (alloc_idx),
        .grant (alloc_grant)
    );

    // R2, R7: lowest free slot, refused during restart
    assign alloc_fire = alloc_req && !restart_req && alloc_hit[0];
    assign alloc_oh   = alloc_fire ? alloc_grant : '0;
    assign alloc_ok   = alloc_fire;
    assign alloc_slot = alloc_idx[0];

    lfq_state #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_state (
        .clk       (clk),
        .rst       (rst),
        .alloc_oh  (alloc_oh),
        .wake_mask (wake_mask),
        .kill      (kill),
        .ret_grant (ret_grant),
        .free_q    (free_map),
        .wait_q    (wait_map),
        .ready_q   (ready_map),
        .count_q   (occupancy)
    );

    lfq_payload #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .BMASK_W(BMASK_W), .TAG_W(TAG_W), .TID_W(TID_W), .CYC_W(CYC_W),
        .RET_W(RET_W)
    ) u_payload (
        .clk     (clk),
        .rst     (rst),
        .we      (alloc_fire),
        .widx    (alloc_idx[0]),
        .w_addr  (alloc_addr),
        .w_data  (alloc_data),
        .w_bmask (alloc_bmask),
        .w_tag   (alloc_tag),
        .w_tid   (alloc_tid),
        .w_stamp (cyc_q),
        .ridx    (ret_slot),
        .r_addr  (ret_addr),
        .r_data  (ret_data),
        .r_bmask (ret_bmask),
        .r_tag   (ret_tag),
        .r_stamp (ret_stamp),
        .tid_all (tid_all)
    );

    // R5: the miss buffer drops an annulled slot from its wake lists
    assign mb_drop_req  = annul_req && !free_map[annul_slot];
    assign mb_drop_slot = annul_slot;

    // R4: number of valid lanes
    always_comb begin
        ret_count = '0;
        for (int l = 0; l < RET_W; l++) begin
            ret_count = ret_count + RC_W'(ret_valid[l]);
        end
    end

    // R10
    assign full = (occupancy == CNT_W'(DEPTH));

    // R9: latency accumulation with wraparound rejection
    always_comb begin
        logic [CYC_W-1:0] delta;
        lat_add = '0;
        for (int l = 0; l < RET_W; l++) begin
            delta = cyc_q - ret_stamp[l];
            if (ret_valid[l] && (delta < CYC_W'(LAT_LIMIT))) begin
                lat_add = lat_add + SUM_W'(delta);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q     <= '0;
            lat_total <= '0;
        end else begin
            cyc_q     <= cyc_q + 1'b1;
            lat_total <= lat_total + lat_add;
        end
    end

endmodule

// File: rtl/ldfill_queue_chk.sv
module ldfill_queue_chk #(
    parameter int DEPTH = 8,
    parameter int RET_W = 2,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4,
    parameter int RC_W  = 2
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         alloc_ok,
    input logic [IDX_W-1:0]             alloc_slot,
    input logic                         full,
    input logic [CNT_W-1:0]             occupancy,
    input logic [RET_W-1:0]             ret_valid,
    input logic [RET_W-1:0][IDX_W-1:0]  ret_slot,
    input logic [RC_W-1:0]              ret_count,
    input logic                         restart_req,
    input logic [DEPTH-1:0]             free_map,
    input logic [DEPTH-1:0]             wait_map,
    input logic [DEPTH-1:0]             ready_map
);

    a_r1_one_state: assert property (@(posedge clk) disable iff (rst)
        ((free_map & wait_map) == '0) && ((free_map & ready_map) == '0) &&
        ((wait_map & ready_map) == '0) && ((free_map | wait_map | ready_map) == '1));

    a_r2_full_refuses: assert property (@(posedge clk) disable iff (rst)
        full |-> !alloc_ok);

    a_r2_alloc_waits: assert property (@(posedge clk) disable iff (rst)
        alloc_ok |=> wait_map[$past(alloc_slot)]);

    a_r4_count_matches: assert property (@(posedge clk) disable iff (rst)
        $countones(ret_valid) == 32'(ret_count));

    a_r4_retire_frees: assert property (@(posedge clk) disable iff (rst)
        ret_valid[0] |=> free_map[$past(ret_slot[0])]);

    a_r4_from_ready: assert property (@(posedge clk) disable iff (rst)
        ret_valid[0] |-> ready_map[ret_slot[0]]);

    generate
        if (RET_W >= 2) begin : g_order
            a_r4_lane_order: assert property (@(posedge clk) disable iff (rst)
                ret_valid[1] |-> (ret_valid[0] && (ret_slot[1] > ret_slot[0])));
        end
    endgenerate

    a_r7_restart_empties: assert property (@(posedge clk) disable iff (rst)
        restart_req |=> (occupancy == '0));

    a_r10_occupancy: assert property (@(posedge clk) disable iff (rst)
        $countones(~free_map) == 32'(occupancy));

endmodule

bind ldfill_queue ldfill_queue_chk #(
    .DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .RC_W(RC_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_ok    (alloc_ok),
    .alloc_slot  (alloc_slot),
    .full        (full),
    .occupancy   (occupancy),
    .ret_valid   (ret_valid),
    .ret_slot    (ret_slot),
    .ret_count   (ret_count),
    .restart_req (restart_req),
    .free_map    (free_map),
    .wait_map    (wait_map),
    .ready_map   (ready_map)
);

// File: tb/sim_ldfill_queue.sv
module sim_ldfill_queue;

    localparam int D = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              a_v = 0;
    logic [31:0]       a_addr = 0;
    logic [63:0]       a_data = 0;
    logic [7:0]        a_bm = 0;
    logic [7:0]        a_tag = 0;
    logic [1:0]        a_tid = 0;
    logic [D-1:0]      w_mask = 0;
    logic              n_v = 0;
    logic [2:0]        n_slot = 0;
    logic              f_v = 0;
    logic [1:0]        f_tid = 0;
    logic              rs = 0;

    logic              alloc_ok, mb_drop_req, full;
    logic [2:0]        alloc_slot, mb_drop_slot;
    logic [1:0]        ret_valid, ret_count;
    logic [1:0][2:0]   ret_slot;
    logic [1:0][7:0]   ret_tag, ret_bmask;
    logic [1:0][31:0]  ret_addr;
    logic [1:0][63:0]  ret_data;
    logic [3:0]        occupancy;
    logic [31:0]       lat_total;

    ldfill_queue u0 (
        .clk(clk), .rst(rst),
        .alloc_req(a_v), .alloc_addr(a_addr), .alloc_data(a_data),
        .alloc_bmask(a_bm), .alloc_tag(a_tag), .alloc_tid(a_tid),
        .alloc_ok(alloc_ok), .alloc_slot(alloc_slot),
        .wake_mask(w_mask),
        .annul_req(n_v), .annul_slot(n_slot),
        .mb_drop_req(mb_drop_req), .mb_drop_slot(mb_drop_slot),
        .flush_req(f_v), .flush_tid(f_tid), .restart_req(rs),
        .ret_valid(ret_valid), .ret_slot(ret_slot), .ret_tag(ret_tag),
        .ret_addr(ret_addr), .ret_data(ret_data), .ret_bmask(ret_bmask),
        .ret_count(ret_count), .occupancy(occupancy), .full(full),
        .lat_total(lat_total)
    );

    // reference model state: 0 free, 1 waiting, 2 ready
    int          st [D];
    logic [31:0] m_addr [D];
    logic [63:0] m_data [D];
    logic [7:0]  m_bm [D];
    logic [7:0]  m_tag [D];
    logic [1:0]  m_tid [D];
    longint      stamp [D];
    longint      cyc = 0;
    longint      lat = 0;
    int          cnt = 0;

    int    nchk = 0;
    int    nfail = 0;
    string phase = "R1";
    bit    done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s (phase %s): actual %0h expected %0h", req, what, phase, act, exp);
        end
    endtask

    task automatic cycle();
        bit     killv [D];
        int     e_slot [2];
        int     k;
        bit     e_ok;
        int     e_as;
        bit     e_drop;
        longint d;
        #1;
        for (int i = 0; i < D; i++)
            killv[i] = (st[i] != 0) && (rs || (n_v && n_slot == 3'(i)) ||
                                        (f_v && m_tid[i] == f_tid));
        k = 0;
        for (int i = 0; i < D; i++)
            if (st[i] == 2 && !killv[i] && k < 2) begin e_slot[k] = i; k++; end
        e_ok = 0; e_as = 0;
        if (a_v && !rs)
            for (int i = D - 1; i >= 0; i--) if (st[i] == 0) begin e_ok = 1; e_as = i; end
        e_drop = n_v && (st[n_slot] != 0);

        chk(alloc_ok == e_ok, "R2", "alloc_ok", alloc_ok, e_ok);
        if (e_ok) chk(alloc_slot == 3'(e_as), "R2", "alloc_slot", alloc_slot, e_as);
        chk(ret_count == 2'(k), "R4", "ret_count", ret_count, k);
        for (int l = 0; l < 2; l++) begin
            chk(ret_valid[l] == (l < k), "R4", "ret_valid", ret_valid[l], (l < k));
            if (l < k) begin
                chk(ret_slot[l] == 3'(e_slot[l]), "R4", "ret_slot", ret_slot[l], e_slot[l]);
                chk(ret_tag[l] == m_tag[e_slot[l]], "R4", "ret_tag", ret_tag[l], m_tag[e_slot[l]]);
                chk(ret_addr[l] == m_addr[e_slot[l]], "R4", "ret_addr", ret_addr[l], m_addr[e_slot[l]]);
                chk(ret_data[l] == m_data[e_slot[l]], "R4", "ret_data", ret_data[l], m_data[e_slot[l]]);
                chk(ret_bmask[l] == m_bm[e_slot[l]], "R4", "ret_bmask", ret_bmask[l], m_bm[e_slot[l]]);
            end
        end
        chk(mb_drop_req == e_drop, "R5", "mb_drop_req", mb_drop_req, e_drop);
        if (e_drop) chk(mb_drop_slot == n_slot, "R5", "mb_drop_slot", mb_drop_slot, n_slot);
        chk(occupancy == 4'(cnt), "R10", "occupancy", occupancy, cnt);
        chk(full == (cnt == D), "R10", "full", full, (cnt == D));
        chk(lat_total == lat[31:0], "R9", "lat_total", lat_total, lat[31:0]);

        // model update
        for (int l = 0; l < k; l++) begin
            d = cyc - stamp[e_slot[l]];
            if (d < 65536) lat += d;
            st[e_slot[l]] = 0;
        end
        for (int i = 0; i < D; i++) if (killv[i]) st[i] = 0;
        for (int i = 0; i < D; i++) if (st[i] == 1 && w_mask[i]) st[i] = 2;
        if (e_ok) begin
            st[e_as] = 1; m_addr[e_as] = a_addr; m_data[e_as] = a_data;
            m_bm[e_as] = a_bm; m_tag[e_as] = a_tag; m_tid[e_as] = a_tid;
            stamp[e_as] = cyc;
        end
        cyc++;
        cnt = 0;
        for (int i = 0; i < D; i++) if (st[i] != 0) cnt++;

        @(negedge clk);
        a_v = 0; w_mask = 0; n_v = 0; f_v = 0; rs = 0;
    endtask

    task automatic req(input logic [7:0] tag, input logic [1:0] tid);
        a_v = 1; a_tag = tag; a_tid = tid;
        a_addr = {tag, 24'h00c0de} ^ 32'(cyc);
        a_data = {$urandom, $urandom};
        a_bm = 8'($urandom);
    endtask

    initial begin
        for (int i = 0; i < D; i++) begin
            st[i] = 0; m_tid[i] = 0; m_tag[i] = 0; m_addr[i] = 0;
            m_data[i] = 0; m_bm[i] = 0; stamp[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;

        phase = "R1";                        // reset state
        cycle(); cycle();

        phase = "R2";                        // fill, then refused on full
        for (int i = 0; i < 9; i++) begin req(8'(8'h10 + i), 2'(i % 4)); cycle(); end
        cycle();

        phase = "R3";                        // partial wakeup, stray bits ignored
        w_mask = 8'b0010_0110; cycle();
        w_mask = 8'b0000_0110; cycle();      // already ready bits
        repeat (3) cycle();

        phase = "R11";                       // alloc with wake and retire
        w_mask = 8'hff; req(8'h40, 2'd3); cycle();
        req(8'h41, 2'd0); cycle();
        repeat (5) cycle();

        phase = "R5";                        // annul waiting and free slots
        for (int i = 0; i < 4; i++) begin req(8'(8'h50 + i), 2'(i)); cycle(); end
        n_v = 1; n_slot = 3'd1; cycle();
        n_v = 1; n_slot = 3'd6; cycle();

        phase = "R6";                        // flush one thread
        req(8'h60, 2'd1); cycle();
        f_v = 1; f_tid = 2'd1; cycle();
        f_v = 1; f_tid = 2'd3; cycle();

        phase = "R8";                        // kill a slot as it becomes retirable
        w_mask = 8'hff; cycle();
        n_v = 1; n_slot = 3'd0; cycle();
        repeat (3) cycle();

        phase = "R7";                        // restart refuses allocation
        for (int i = 0; i < 5; i++) begin req(8'(8'h70 + i), 2'd2); cycle(); end
        w_mask = 8'h03; cycle();
        rs = 1; req(8'h7f, 2'd0); cycle();
        cycle();

        phase = "R9";                        // wraparound limit on latency
        req(8'h90, 2'd0); cycle();
        repeat (70000) cycle();
        w_mask = 8'h01; cycle();
        cycle();
        req(8'h91, 2'd1); cycle();
        repeat (20) cycle();
        w_mask = 8'h01; cycle();
        repeat (3) cycle();

        phase = "R4";                        // mixed traffic
        for (int t = 0; t < 4000; t++) begin
            if ($urandom % 2 == 0) req(8'($urandom), 2'($urandom));
            if ($urandom % 3 == 0) w_mask = 8'($urandom);
            if ($urandom % 8 == 0) begin n_v = 1; n_slot = 3'($urandom); end
            if ($urandom % 16 == 0) begin f_v = 1; f_tid = 2'($urandom); end
            if ($urandom % 200 == 0) rs = 1;
            cycle();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R1 watchdog expired in phase %s", phase);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule